// File: doc/BRIEF.md
# Per-Line Edge-Select Interrupt Controller

This block is the interrupt logic that sits behind the input lines of a GPIO expander. It receives input levels that have already been synchronised to its clock. For every line it decides whether an event has happened. Each line can watch for one of four events: a level that differs from the last value software read, a rising edge, a falling edge, or any edge. Each event sets a per-line status bit. The interrupt pin is active low and is asserted while any status bit is set and that line's mask bit is set.

Two behaviours can be chosen per line.

- **Latched line:** the status bit stays set until software reads the input port or writes a clear.
- **Non-latched line:** the status bit is withdrawn by itself when the pin goes back to the level it had before the event.

The read side offers three views:

- The input port read returns the pin levels. It also acknowledges all status bits and captures those levels as the new reference for level mode.
- The peek read returns the same levels with no side effects.
- The status read returns the status vector.

Writes and reads are single-cycle strobes with no back-pressure. A strobe is accepted on every clock in which its enable is high, and read data is valid in the same cycle.

Top module: `gpx_irq_ctrl`

## Requirements
- R1: After reset, all status bits are 0 and `irq_n_o` is 1. Every mask bit is 0, every latch enable is 0, every event select is level, and the level reference is 0. A pulse on a line therefore sets its status bit without asserting the pin, and the bit withdraws when the pin returns low.
- R2: A write with `wr_sel`=0 loads the mask from `wr_data[LINES-1:0]`; mask bit 1 enables that line. `irq_n_o` is 0 exactly when some line has both its status bit and its mask bit set.
- R3: A write with `wr_sel`=1 loads the event select. Line i takes `wr_data[2i+1:2i]`, where 0 = level, 1 = rising, 2 = falling and 3 = any edge. Edges are measured against the line's level in the previous cycle.
- R4: In level mode, an event is present in every cycle in which the pin differs from the value captured at the last input port read. There is no level event in a cycle that performs such a read.
- R5: A write with `wr_sel`=2 loads the latch enables from `wr_data[LINES-1:0]`. On a latched line, a set status bit stays set until an input port read or a clear.
- R6: On a non-latched line with its status set, the bit clears when the pin equals the level it had before the event. For an edge event, that is the level in the cycle before the edge. For a level event, that is the captured reference. This withdrawal takes precedence over a new event in the same cycle.
- R7: A write with `wr_sel`=3 clears every status bit whose `wr_data[LINES-1:0]` bit is 1.
- R8: When `rd_en`=1, `rd_sel` selects the read view. 0 is the input port read, which returns the pins, clears status and captures the reference. 1 is the peek read, which returns the pins with no effect on status or reference. 2 returns the status vector. 3, or `rd_en`=0, returns 0.
- R9: If an event occurs in the same cycle as an input port read or a clear on that line, the event wins and the status bit is set.
- R10: A status bit changes on the clock edge that ends the cycle in which its cause was present. `irq_n_o` follows the status and mask registers with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | LINES | Synchronised input line levels |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 event select, 2 latch enable, 3 clear |
| wr_data | input | 2*LINES | Write data |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 2 | Read view: 0 input port, 1 peek, 2 status |
| rd_data | output | LINES | Read data, valid in the strobe cycle |
| status_o | output | LINES | Per-line status vector |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with LINES=4 and gives each line its own event select (line i uses code i). All four modes are therefore present in every cycle, and one pin pattern tests level, rising, falling and any-edge behaviour side by side. This makes the precedence cases reachable in single cycles: withdrawal against an opposite edge on an any-edge line, and a read or clear against a new edge. A reference model that tracks pre-event levels and the read reference is compared on every clock, through directed sequences and then through a long stretch of random pins, strobes and writes.

// File: rtl/gpx_irq_pkg.sv
package gpx_irq_pkg;

  typedef enum logic [1:0] {
    WSEL_MASK  = 2'd0,
    WSEL_EDGE  = 2'd1,
    WSEL_LATCH = 2'd2,
    WSEL_CLEAR = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    RSEL_PORT   = 2'd0,
    RSEL_PEEK   = 2'd1,
    RSEL_STATUS = 2'd2,
    RSEL_NONE   = 2'd3
  } rd_sel_e;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'd0,
    EV_RISE  = 2'd1,
    EV_FALL  = 2'd2,
    EV_ANY   = 2'd3
  } ev_mode_e;

  localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/gpx_irq_cfg.sv
module gpx_irq_cfg
  import gpx_irq_pkg::*;
#(
  parameter int unsigned LINES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_sel,
  input  logic [MODE_W*LINES-1:0]   wr_data,
  output logic [LINES-1:0]          mask_o,
  output logic [MODE_W*LINES-1:0]   mode_o,
  output logic [LINES-1:0]          latch_o,
  output logic [LINES-1:0]          clr_o
);

  localparam int unsigned MW = MODE_W * LINES;

  wr_sel_e             sel;
  logic [LINES-1:0]    mask_q;
  logic [MW-1:0]       mode_q;
  logic [LINES-1:0]    latch_q;

  assign sel = wr_sel_e'(wr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      mode_q  <= '0;
      latch_q <= '0;
    end else if (wr_en) begin
      case (sel)
        WSEL_MASK:  mask_q  <= wr_data[LINES-1:0];
        WSEL_EDGE:  mode_q  <= wr_data;
        WSEL_LATCH: latch_q <= wr_data[LINES-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_o = '0;
    if (wr_en && sel == WSEL_CLEAR) clr_o = wr_data[LINES-1:0];
  end

  assign mask_o  = mask_q;
  assign mode_o  = mode_q;
  assign latch_o = latch_q;

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> (mask_o == $past(wr_data[LINES-1:0]))); // R2

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> (mode_o == $past(wr_data))); // R3

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> (latch_o == $past(wr_data[LINES-1:0]))); // R5

endmodule

// File: rtl/gpx_irq_line.sv
module gpx_irq_line
  import gpx_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              latch_i,
  input  logic              port_rd_i,
  input  logic              clr_i,
  output logic              stat_o
);

  ev_mode_e mode;
  logic     prev_q;
  logic     ref_q;
  logic     pre_q;
  logic     stat_q;
  logic     rise;
  logic     fall;
  logic     ev;
  logic     wd;
  logic     src;

  assign mode = ev_mode_e'(mode_i);

  always_comb begin
    rise = pin_i & ~prev_q;
    fall = ~pin_i & prev_q;
    case (mode)
      EV_LEVEL: ev = (pin_i != ref_q) & ~port_rd_i;
      EV_RISE:  ev = rise;
      EV_FALL:  ev = fall;
      EV_ANY:   ev = rise | fall;
      default:  ev = 1'b0;
    endcase
    src = (mode == EV_LEVEL) ? ref_q : prev_q;
    wd  = stat_q & ~latch_i & (pin_i == pre_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      ref_q  <= 1'b0;
      pre_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= pin_i;
      if (port_rd_i) ref_q <= pin_i;
      if (wd) begin
        stat_q <= 1'b0;
      end else if (ev) begin
        stat_q <= 1'b1;
        pre_q  <= src;
      end else if (port_rd_i || clr_i) begin
        stat_q <= 1'b0;
      end
    end
  end

  assign stat_o = stat_q;

  AST_REF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd_i |=> (ref_q == $past(pin_i))); // R4

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && latch_i && !port_rd_i && !clr_i) |=> stat_q); // R5

  AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    wd |=> !stat_q); // R6

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((port_rd_i || clr_i) && !ev) |=> !stat_q); // R7

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !wd) |=> stat_q); // R9

endmodule

// File: rtl/gpx_irq_rdmux.sv
module gpx_irq_rdmux
  import gpx_irq_pkg::*;
#(
  parameter int unsigned LINES = 8
) (
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  input  logic [LINES-1:0] pin_i,
  input  logic [LINES-1:0] stat_i,
  output logic [LINES-1:0] rd_data_o,
  output logic             port_rd_o
);

  rd_sel_e sel;
  assign sel = rd_sel_e'(rd_sel);

  always_comb begin
    rd_data_o = '0;
    port_rd_o = 1'b0;
    if (rd_en) begin
      case (sel)
        RSEL_PORT: begin
          rd_data_o = pin_i;
          port_rd_o = 1'b1;
        end
        RSEL_PEEK:   rd_data_o = pin_i;
        RSEL_STATUS: rd_data_o = stat_i;
        default:     rd_data_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpx_irq_ctrl.sv
module gpx_irq_ctrl
  import gpx_irq_pkg::*;
#(
  parameter int unsigned LINES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES-1:0]         pin_i,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [MODE_W*LINES-1:0]  wr_data,
  input  logic                     rd_en,
  input  logic [1:0]               rd_sel,
  output logic [LINES-1:0]         rd_data,
  output logic [LINES-1:0]         status_o,
  output logic                     irq_n_o
);

  localparam int unsigned MW = MODE_W * LINES;

  logic [LINES-1:0] mask;
  logic [MW-1:0]    mode;
  logic [LINES-1:0] latch;
  logic [LINES-1:0] clr;
  logic [LINES-1:0] stat;
  logic             port_rd;

  gpx_irq_cfg #(.LINES(LINES)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .mask_o  (mask),
    .mode_o  (mode),
    .latch_o (latch),
    .clr_o   (clr)
  );

  gpx_irq_rdmux #(.LINES(LINES)) u_rd (
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .pin_i     (pin_i),
    .stat_i    (stat),
    .rd_data_o (rd_data),
    .port_rd_o (port_rd)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    gpx_irq_line u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pin_i[g]),
      .mode_i    (mode[MODE_W*g +: MODE_W]),
      .latch_i   (latch[g]),
      .port_rd_i (port_rd),
      .clr_i     (clr[g]),
      .stat_o    (stat[g])
    );
  end

  assign status_o = stat;
  assign irq_n_o  = ~|(stat & mask);

  AST_MASK_UPDATE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && wr_data[LINES-1:0] == '0) |=> irq_n_o); // R2

endmodule

// File: tb/gpx_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpx_irq_ctrl_tb_top;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_i = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [2*N-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [1:0]   rd_sel = '0;
  logic [N-1:0] rd_data;
  logic [N-1:0] status_o;
  logic         irq_n_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  gpx_irq_ctrl #(.LINES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .status_o(status_o), .irq_n_o(irq_n_o)
  );

  // behavioural reference model
  logic [N-1:0] m_stat, m_prev, m_ref, m_pre, m_mask, m_latch;
  int m_mode[N];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = '0; m_prev = '0; m_ref = '0; m_pre = '0;
      m_mask = '0; m_latch = '0;
      for (int i = 0; i < N; i++) m_mode[i] = 0;
    end else begin
      bit prd;
      prd = rd_en && (rd_sel == 2'd0);
      for (int i = 0; i < N; i++) begin
        bit p, ev, wd, clr;
        p = pin_i[i];
        clr = wr_en && (wr_sel == 2'd3) && wr_data[i];
        if (m_mode[i] == 0)      ev = (p != m_ref[i]) && !prd;
        else if (m_mode[i] == 1) ev = p && !m_prev[i];
        else if (m_mode[i] == 2) ev = !p && m_prev[i];
        else                     ev = (p != m_prev[i]);
        wd = m_stat[i] && !m_latch[i] && (p == m_pre[i]);
        if (wd) m_stat[i] = 1'b0;
        else if (ev) begin
          m_stat[i] = 1'b1;
          m_pre[i] = (m_mode[i] == 0) ? m_ref[i] : m_prev[i];
        end else if (prd || clr) m_stat[i] = 1'b0;
        m_prev[i] = p;
        if (prd) m_ref[i] = p;
      end
      if (wr_en) begin
        if (wr_sel == 2'd0) m_mask = wr_data[N-1:0];
        else if (wr_sel == 2'd1) for (int i = 0; i < N; i++) m_mode[i] = int'(wr_data[2*i +: 2]);
        else if (wr_sel == 2'd2) m_latch = wr_data[N-1:0];
      end
    end
  end

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      logic [N-1:0] erd;
      chk("R10 status", 8'(status_o), 8'(m_stat));
      chk("R2 irq", 8'(irq_n_o), 8'(!(|(m_stat & m_mask))));
      if (!rd_en || rd_sel == 2'd3) erd = '0;
      else if (rd_sel == 2'd2) erd = m_stat;
      else erd = pin_i;
      chk("R8 rd_data", 8'(rd_data), 8'(erd));
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic nxt();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d; nxt(); wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) nxt();
    rst_n = 1'b1;
    chk("R1 status reset", 8'(status_o), 8'h0);
    chk("R1 irq reset", 8'(irq_n_o), 8'h1);
    cmp_on = 1'b1;
    // R1: default level mode, unlatched, masked
    pin_i = 4'b0001; nxt();
    chk("R1 level default sets", 8'(status_o), 8'h1);
    chk("R1 mask default off", 8'(irq_n_o), 8'h1);
    pin_i = 4'b0000; nxt();
    chk("R1 unlatched withdraw", 8'(status_o), 8'h0);
    // configure: all enabled, line i uses mode i
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'hE4);
    nxt();
    pin_i = 4'b1111; nxt();
    chk("R3 modes on rise", 8'(status_o), 8'h0B);
    chk("R2 irq asserted", 8'(irq_n_o), 8'h0);
    pin_i = 4'b0000; nxt();
    chk("R6 withdraw and falling", 8'(status_o), 8'h04);
    nxt();
    chk("R6 holds while differing", 8'(status_o), 8'h04);
    rd_en = 1'b1; rd_sel = 2'd1; nxt();
    rd_en = 1'b0;
    chk("R8 peek no side effect", 8'(status_o), 8'h04);
    rd_en = 1'b1; rd_sel = 2'd0; nxt();
    rd_en = 1'b0;
    chk("R8 port read clears", 8'(status_o), 8'h00);
    // latched
    wr(2'd2, 8'h0F);
    pin_i = 4'b1111; nxt();
    chk("R5 latched set", 8'(status_o), 8'h0B);
    pin_i = 4'b0000; nxt();
    chk("R5 latched hold", 8'(status_o), 8'h0F);
    nxt();
    chk("R5 still held", 8'(status_o), 8'h0F);
    wr(2'd3, 8'h03);
    chk("R7 clear selected", 8'(status_o), 8'h0C);
    pin_i = 4'b1010; rd_en = 1'b1; rd_sel = 2'd0; nxt();
    rd_en = 1'b0;
    chk("R9 edge beats read", 8'(status_o), 8'h0A);
    pin_i = 4'b1011; nxt();
    chk("R4 level vs captured", 8'(status_o), 8'h0B);
    wr(2'd0, 8'h04);
    chk("R2 masked irq off", 8'(irq_n_o), 8'h1);
    // random phase
    wr(2'd0, 8'h0F);
    for (int c = 0; c < 600; c++) begin
      pin_i = 4'($urandom);
      rd_en = ($urandom % 4) == 0;
      rd_sel = 2'($urandom);
      wr_en = ($urandom % 6) == 0;
      wr_sel = 2'($urandom);
      wr_data = 8'($urandom);
      nxt();
    end
    wr_en = 1'b0; rd_en = 1'b0;
    nxt();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule